// File: doc/BRIEF.md
# Hotplug Slot Event Register Bank

This block keeps, for each of several hotplug buses, three slot bitmaps: slots with an insertion waiting to be reported, slots with a removal request waiting to be serviced, and slots that may be removed at all. Firmware reaches them through a 32-bit word-only register port. A select register chooses the bus, and the bitmap registers then show that bus. Event inputs from the platform set bits in the bitmaps and raise a one-clock event pulse toward the interrupt controller. An insertion is reported only when the device was hot-added.

Firmware services a removal by writing a slot mask to the eject register. Only the lowest set bit is acted on. That slot's pending insert and remove bits are retired on the selected bus, and a one-clock eject strobe naming the bus and slot goes to the device side, provided the slot is removable. A warm platform reset starts a drain sequence. The sequence ejects every pending removal on every bus, one per cycle, and then reloads each bus's removable bitmap from the fixed-slot mask. In legacy mode an insert read no longer clears the bitmap, and the select register falls outside the decoded window.

Top module: `hp_event_bank`

## Requirements
- R1: An access takes effect only when all four byte enables are set and address bits [1:0] are zero. Reads decode these offsets: 0x00 insert bitmap, 0x04 remove bitmap, 0x08 feature (always zero), 0x0C removable bitmap, 0x10 bus select. Any other offset reads zero, and writes to it are ignored. Every read request gets `rsp_valid` and `rsp_rdata` one cycle later.
- R2: Reading offset 0x10 returns the full 32-bit value last written there.
- R3: When the select value is NUM_BUS or more, every read returns zero, including the select register itself, and eject writes have no effect.
- R4: Outside legacy mode, a read of the insert bitmap returns the bitmap and clears it. An insert event arriving in the same cycle is kept.
- R5: In legacy mode, insert reads do not clear the bitmap. Offset 0x10 is not decoded: it reads zero and writes to it are ignored.
- R6: A write of nonzero data to 0x08 clears the insert and remove bits of the slot given by the lowest set bit, on the selected bus. A write of zero does nothing. An event for that slot in the same cycle is kept.
- R7: An eject produces a one-cycle `eject_valid` with the bus and slot, but only if the slot's removable bit is set at that moment.
- R8: An insert event with the hot-added flag set sets its slot bit and pulses `irq_pulse` in the next cycle. With the flag clear it changes nothing and raises no pulse.
- R9: A remove event sets its slot bit and pulses `irq_pulse`. An insert and a remove in the same cycle set both bits.
- R10: An event naming a bus of NUM_BUS or more is dropped and pulses `evt_err` for one cycle.
- R11: A hard reset clears the insert and remove bitmaps and the select register, and loads each removable bitmap with the inverse of its fixed-slot mask.
- R12: A `warm_rst` pulse raises `drain_busy`. Buses are then visited in ascending order. Each cycle ejects the lowest pending removal of the current bus. When that bus has none left, its removable bitmap is reloaded and the sequence moves to the next bus. Eject writes are ignored while the drain runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| warm_rst | input | 1 | Pulse that starts the pending-removal drain |
| legacy_mode | input | 1 | Non-clearing insert reads, narrower window |
| fixed_mask | input | NUM_BUS*NUM_SLOT | Slots that are not hotpluggable, bus-major |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ins_valid | input | 1 | Insert event |
| ins_bus | input | EVT_BUS_W | Insert bus number |
| ins_slot | input | log2(NUM_SLOT) | Insert slot number |
| ins_hot | input | 1 | Device was hot-added |
| rem_valid | input | 1 | Remove request |
| rem_bus | input | EVT_BUS_W | Remove bus number |
| rem_slot | input | log2(NUM_SLOT) | Remove slot number |
| irq_pulse | output | 1 | One-clock event notification |
| evt_err | output | 1 | Event named a nonexistent bus |
| eject_valid | output | 1 | Eject strobe |
| eject_bus | output | log2(NUM_BUS) | Bus of the ejected slot |
| eject_slot | output | log2(NUM_SLOT) | Ejected slot |
| drain_busy | output | 1 | Drain sequence running |

## Verification
The bench builds the block with four buses of 32 slots and a 3-bit event bus field. With that field, bus numbers 4 to 7 can be driven to reach the dropped-event error. Full-width slot maps let the lowest-set-bit eject and the drain reach slot 31. The fixed-slot mask marks one slot on bus 0 and one on bus 1, so both the suppressed strobe and the removable reload after the drain become visible.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned IDX_W  = $clog2(REG_W) + 1;

    typedef enum logic [2:0] {
        RG_INS,
        RG_REM,
        RG_FEAT,
        RG_RMV,
        RG_SEL,
        RG_NONE
    } reg_e;

    function automatic reg_e decode_reg(input logic [ADDR_W-1:0] a, input logic legacy);
        case (a)
            5'h00:   return RG_INS;
            5'h04:   return RG_REM;
            5'h08:   return RG_FEAT;
            5'h0C:   return RG_RMV;
            5'h10:   return legacy ? RG_NONE : RG_SEL;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(input logic [REG_W-1:0] v);
        logic [IDX_W-1:0] idx;
        idx = IDX_W'(REG_W);
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (v[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/hp_evt_in.sv
module hp_evt_in #(
    parameter int unsigned NUM_BUS   = 4,
    parameter int unsigned NUM_SLOT  = 32,
    parameter int unsigned EVT_BUS_W = 3,
    parameter int unsigned SLOT_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ins_valid,
    input  logic [EVT_BUS_W-1:0]         ins_bus,
    input  logic [SLOT_W-1:0]            ins_slot,
    input  logic                         ins_hot,
    input  logic                         rem_valid,
    input  logic [EVT_BUS_W-1:0]         rem_bus,
    input  logic [SLOT_W-1:0]            rem_slot,
    output logic [NUM_BUS*NUM_SLOT-1:0]  ins_set,
    output logic [NUM_BUS*NUM_SLOT-1:0]  rem_set,
    output logic                         irq_pulse,
    output logic                         evt_err
);
    logic ins_in_range, rem_in_range, ins_take, rem_take;

    assign ins_in_range = int'(ins_bus) < int'(NUM_BUS);
    assign rem_in_range = int'(rem_bus) < int'(NUM_BUS);
    assign ins_take     = ins_valid && ins_hot && ins_in_range;
    assign rem_take     = rem_valid && rem_in_range;

    always_comb begin
        ins_set = '0;
        rem_set = '0;
        for (int b = 0; b < int'(NUM_BUS); b++) begin
            if (ins_take && ins_bus == EVT_BUS_W'(b))
                ins_set[b*NUM_SLOT +: NUM_SLOT] = NUM_SLOT'(1) << ins_slot;
            if (rem_take && rem_bus == EVT_BUS_W'(b))
                rem_set[b*NUM_SLOT +: NUM_SLOT] = NUM_SLOT'(1) << rem_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            evt_err   <= 1'b0;
        end else begin
            irq_pulse <= ins_take || rem_take;
            evt_err   <= (ins_valid && !ins_in_range) || (rem_valid && !rem_in_range);
        end
    end

    // R10: an error pulse never comes with an accepted event on the same input alone
    p_err_no_set_r10: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_in_range && !rem_valid) |-> (ins_set == '0 && rem_set == '0));
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
    parameter int unsigned NUM_SLOT = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SLOT-1:0] set_ins,
    input  logic [NUM_SLOT-1:0] set_rem,
    input  logic [NUM_SLOT-1:0] clr,
    input  logic                rd_clr,
    input  logic                load_rmv,
    input  logic [NUM_SLOT-1:0] fixed,
    output logic [NUM_SLOT-1:0] ins_q,
    output logic [NUM_SLOT-1:0] rem_q,
    output logic [NUM_SLOT-1:0] rmv_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q <= '0;
            rem_q <= '0;
            rmv_q <= ~fixed;
        end else begin
            ins_q <= ((rd_clr ? '0 : ins_q) & ~clr) | set_ins;
            rem_q <= (rem_q & ~clr) | set_rem;
            if (load_rmv) rmv_q <= ~fixed;
        end
    end

    // R9: a remove event always lands, even against a same-cycle eject
    p_rem_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (set_rem != '0) |=> ((rem_q & $past(set_rem)) == $past(set_rem)));

    // R5: without a clearing read or eject, no insert bit is lost
    p_ins_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!rd_clr && clr == '0) |=> ((ins_q & $past(ins_q)) == $past(ins_q)));

    // R6: an eject retires the remove bit unless the same slot is re-requested
    p_eject_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (clr != '0 && (set_rem & clr) == '0) |=> ((rem_q & $past(clr)) == '0));
endmodule

// File: rtl/hp_event_bank.sv
module hp_event_bank
    import hp_pkg::*;
#(
    parameter int unsigned NUM_BUS   = 4,
    parameter int unsigned NUM_SLOT  = 32,
    parameter int unsigned EVT_BUS_W = 3,
    localparam int unsigned SLOT_W   = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
    localparam int unsigned BUS_W    = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        warm_rst,
    input  logic                        legacy_mode,
    input  logic [NUM_BUS*NUM_SLOT-1:0] fixed_mask,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [3:0]                  req_be,
    input  logic [REG_W-1:0]            req_wdata,
    output logic                        rsp_valid,
    output logic [REG_W-1:0]            rsp_rdata,
    input  logic                        ins_valid,
    input  logic [EVT_BUS_W-1:0]        ins_bus,
    input  logic [SLOT_W-1:0]           ins_slot,
    input  logic                        ins_hot,
    input  logic                        rem_valid,
    input  logic [EVT_BUS_W-1:0]        rem_bus,
    input  logic [SLOT_W-1:0]           rem_slot,
    output logic                        irq_pulse,
    output logic                        evt_err,
    output logic                        eject_valid,
    output logic [BUS_W-1:0]            eject_bus,
    output logic [SLOT_W-1:0]           eject_slot,
    output logic                        drain_busy
);
    localparam int unsigned FLAT_W = NUM_BUS * NUM_SLOT;

    logic [FLAT_W-1:0]   ins_set, rem_set;
    logic [NUM_SLOT-1:0] ins_w [NUM_BUS];
    logic [NUM_SLOT-1:0] rem_w [NUM_BUS];
    logic [NUM_SLOT-1:0] rmv_w [NUM_BUS];
    logic [NUM_SLOT-1:0] clr_mask [NUM_BUS];
    logic [NUM_BUS-1:0]  rd_clr, load_rmv;

    hp_evt_in #(
        .NUM_BUS(NUM_BUS), .NUM_SLOT(NUM_SLOT), .EVT_BUS_W(EVT_BUS_W), .SLOT_W(SLOT_W)
    ) u_evt (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_bus(ins_bus), .ins_slot(ins_slot), .ins_hot(ins_hot),
        .rem_valid(rem_valid), .rem_bus(rem_bus), .rem_slot(rem_slot),
        .ins_set(ins_set), .rem_set(rem_set),
        .irq_pulse(irq_pulse), .evt_err(evt_err)
    );

    // register port decode
    logic             word_ok, sel_ok, rd_req;
    reg_e             rg;
    logic [REG_W-1:0] sel_q, rd_val;
    logic [BUS_W-1:0] sel_idx;

    assign word_ok = req_valid && (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
    assign rd_req  = req_valid && !req_write;
    assign rg      = decode_reg(req_addr, legacy_mode);
    assign sel_ok  = sel_q < REG_W'(NUM_BUS);
    assign sel_idx = sel_q[BUS_W-1:0];

    always_comb begin
        rd_val = '0;
        if (word_ok && sel_ok) begin
            case (rg)
                RG_INS:  rd_val = REG_W'(ins_w[sel_idx]);
                RG_REM:  rd_val = REG_W'(rem_w[sel_idx]);
                RG_RMV:  rd_val = REG_W'(rmv_w[sel_idx]);
                RG_SEL:  rd_val = sel_q;
                default: rd_val = '0;
            endcase
        end
    end

    // eject source: drain sequence has priority over firmware writes
    logic             drain_q, drain_hit, wr_ej, ej_any;
    logic [BUS_W-1:0] dbus_q, ej_bus;
    logic [REG_W-1:0] drain_vec, ej_vec;
    logic [IDX_W-1:0] ej_idx;
    logic [SLOT_W-1:0] ej_slot;

    assign drain_vec = REG_W'(rem_w[dbus_q]);
    assign drain_hit = drain_q && (drain_vec != '0);
    assign wr_ej     = word_ok && req_write && (rg == RG_FEAT) && sel_ok
                       && (req_wdata != '0) && !drain_q;
    assign ej_vec    = drain_q ? drain_vec : req_wdata;
    assign ej_bus    = drain_q ? dbus_q : sel_idx;
    assign ej_idx    = lowest_set(ej_vec);
    assign ej_slot   = SLOT_W'(ej_idx);
    assign ej_any    = (drain_q ? drain_hit : wr_ej) && (int'(ej_idx) < int'(NUM_SLOT));

    for (genvar b = 0; b < int'(NUM_BUS); b++) begin : g_bus
        assign clr_mask[b] = (ej_any && ej_bus == BUS_W'(b)) ? (NUM_SLOT'(1) << ej_slot) : '0;
        assign rd_clr[b]   = word_ok && rd_req && (rg == RG_INS) && sel_ok
                             && !legacy_mode && (sel_idx == BUS_W'(b));
        assign load_rmv[b] = drain_q && !drain_hit && (dbus_q == BUS_W'(b));

        hp_slot_bank #(.NUM_SLOT(NUM_SLOT)) u_bank (
            .clk(clk), .rst(rst),
            .set_ins(ins_set[b*NUM_SLOT +: NUM_SLOT]),
            .set_rem(rem_set[b*NUM_SLOT +: NUM_SLOT]),
            .clr(clr_mask[b]), .rd_clr(rd_clr[b]), .load_rmv(load_rmv[b]),
            .fixed(fixed_mask[b*NUM_SLOT +: NUM_SLOT]),
            .ins_q(ins_w[b]), .rem_q(rem_w[b]), .rmv_q(rmv_w[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q       <= '0;
            drain_q     <= 1'b0;
            dbus_q      <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            eject_valid <= 1'b0;
            eject_bus   <= '0;
            eject_slot  <= '0;
        end else begin
            rsp_valid   <= rd_req;
            rsp_rdata   <= rd_req ? rd_val : '0;
            if (word_ok && req_write && rg == RG_SEL) sel_q <= req_wdata;
            eject_valid <= ej_any && rmv_w[ej_bus][ej_slot];
            if (ej_any) begin
                eject_bus  <= ej_bus;
                eject_slot <= ej_slot;
            end
            if (warm_rst) begin
                drain_q <= 1'b1;
                dbus_q  <= '0;
            end else if (drain_q && !drain_hit) begin
                if (dbus_q == BUS_W'(NUM_BUS - 1)) drain_q <= 1'b0;
                else dbus_q <= dbus_q + 1'b1;
            end
        end
    end

    assign drain_busy = drain_q;

    // R1: a response only ever follows a read request
    p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R3: with an out-of-range select, read data is zero
    p_oor_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(sel_q) >= REG_W'(NUM_BUS))) |-> (rsp_rdata == '0));

    // R7: a strobe always names an existing bus
    p_eject_bus_range_r7: assert property (@(posedge clk) disable iff (rst)
        eject_valid |-> (int'(eject_bus) < int'(NUM_BUS)));

    // R12: during the drain, strobes come from the bus being drained
    p_drain_bus_r12: assert property (@(posedge clk) disable iff (rst)
        (eject_valid && $past(drain_q)) |-> (eject_bus == $past(dbus_q)));
endmodule

// File: tb/hp_event_bank_tb.sv
`timescale 1ns/1ps
module hp_event_bank_tb;
    localparam int NB = 4;
    localparam int NS = 32;
    localparam logic [NB*NS-1:0] FIXED = {32'h0, 32'h0, 32'h0000_0008, 32'h8000_0000};

    logic clk = 1'b0, rst = 1'b1, warm_rst = 1'b0, legacy_mode = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_addr = '0;
    logic [3:0] req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic ins_valid = 1'b0, ins_hot = 1'b0, rem_valid = 1'b0;
    logic [2:0] ins_bus = '0, rem_bus = '0;
    logic [4:0] ins_slot = '0, rem_slot = '0;
    logic irq_pulse, evt_err, eject_valid, drain_busy;
    logic [1:0] eject_bus;
    logic [4:0] eject_slot;

    hp_event_bank #(.NUM_BUS(NB), .NUM_SLOT(NS), .EVT_BUS_W(3)) u_dut (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .legacy_mode(legacy_mode),
        .fixed_mask(FIXED), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ins_valid(ins_valid), .ins_bus(ins_bus), .ins_slot(ins_slot), .ins_hot(ins_hot),
        .rem_valid(rem_valid), .rem_bus(rem_bus), .rem_slot(rem_slot),
        .irq_pulse(irq_pulse), .evt_err(evt_err), .eject_valid(eject_valid),
        .eject_bus(eject_bus), .eject_slot(eject_slot), .drain_busy(drain_busy)
    );

    initial forever #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    string cur_req = "R11";
    bit done = 1'b0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_ins[NB], m_rem[NB], m_rmv[NB];
    bit [31:0] m_sel, rv;
    bit m_drain, e_rsp_v, e_irq, e_err, e_ej_v, e_drain, word, ea, load;
    bit [31:0] e_rd;
    int m_dbus, e_ej_bus, e_ej_slot, sb, eb, es;

    function automatic int lsb(input bit [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                m_ins[b] = 0; m_rem[b] = 0; m_rmv[b] = ~FIXED[b*NS +: NS];
            end
            m_sel = 0; m_drain = 0; m_dbus = 0;
            e_rsp_v = 0; e_rd = 0; e_irq = 0; e_err = 0; e_ej_v = 0;
            e_ej_bus = 0; e_ej_slot = 0; e_drain = 0;
        end else begin
            word = req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00;
            sb = (m_sel < NB) ? int'(m_sel) : -1;
            rv = 0;
            if (word && sb >= 0) begin
                if (req_addr == 5'h00) rv = m_ins[sb];
                if (req_addr == 5'h04) rv = m_rem[sb];
                if (req_addr == 5'h0C) rv = m_rmv[sb];
                if (req_addr == 5'h10 && !legacy_mode) rv = m_sel;
            end
            e_rsp_v = req_valid && !req_write;
            e_rd = e_rsp_v ? rv : 0;
            ea = 0; load = 0; eb = 0; es = 0;
            if (m_drain) begin
                if (m_rem[m_dbus] != 0) begin ea = 1; eb = m_dbus; es = lsb(m_rem[m_dbus]); end
                else load = 1;
            end else if (word && req_write && req_addr == 5'h08 && sb >= 0 && req_wdata != 0) begin
                ea = 1; eb = sb; es = lsb(req_wdata);
            end
            e_ej_v = ea && m_rmv[eb][es];
            if (ea) begin e_ej_bus = eb; e_ej_slot = es; end
            if (word && !req_write && req_addr == 5'h00 && sb >= 0 && !legacy_mode) m_ins[sb] = 0;
            if (ea) begin m_ins[eb][es] = 0; m_rem[eb][es] = 0; end
            if (load) m_rmv[m_dbus] = ~FIXED[m_dbus*NS +: NS];
            e_irq = 0; e_err = 0;
            if (ins_valid) begin
                if (ins_bus < NB) begin
                    if (ins_hot) begin m_ins[ins_bus][ins_slot] = 1; e_irq = 1; end
                end else e_err = 1;
            end
            if (rem_valid) begin
                if (rem_bus < NB) begin m_rem[rem_bus][rem_slot] = 1; e_irq = 1; end
                else e_err = 1;
            end
            if (word && req_write && req_addr == 5'h10 && !legacy_mode) m_sel = req_wdata;
            if (warm_rst) begin m_drain = 1; m_dbus = 0; end
            else if (load) begin
                if (m_dbus == NB - 1) m_drain = 0; else m_dbus++;
            end
            e_drain = m_drain;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("rsp_valid", 32'(rsp_valid), 32'(e_rsp_v));
            check("rsp_rdata", rsp_rdata, e_rd);
            check("irq_pulse", 32'(irq_pulse), 32'(e_irq));
            check("evt_err", 32'(evt_err), 32'(e_err));
            check("eject_valid", 32'(eject_valid), 32'(e_ej_v));
            check("drain_busy", 32'(drain_busy), 32'(e_drain));
            if (e_ej_v) begin
                check("eject_bus", 32'(eject_bus), 32'(e_ej_bus));
                check("eject_slot", 32'(eject_slot), 32'(e_ej_slot));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle();
        req_valid = 0; req_write = 0; req_be = 4'hF; req_wdata = 0;
        ins_valid = 0; rem_valid = 0; ins_hot = 0; warm_rst = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string what);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk); idle();
        check(what, rsp_rdata, exp);
    endtask

    task automatic ev(input bit iv, input int ib, input int is, input bit ih,
                      input bit rvv, input int rb, input int rs);
        ins_valid = iv; ins_bus = 3'(ib); ins_slot = 5'(is); ins_hot = ih;
        rem_valid = rvv; rem_bus = 3'(rb); rem_slot = 5'(rs);
        @(negedge clk); idle();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1; checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R11";
        rd_expect(5'h10, 32'h0, "R11 select after reset");
        rd_expect(5'h0C, 32'h7FFF_FFFF, "R11 removable bus0");
        rd_expect(5'h00, 32'h0, "R11 insert bus0");

        cur_req = "R8";
        ev(1, 0, 5, 1, 0, 0, 0);
        rd_expect(5'h00, 32'h0000_0020, "R8 hot insert");
        ev(1, 0, 6, 0, 0, 0, 0);
        rd_expect(5'h00, 32'h0, "R8 cold insert ignored");

        cur_req = "R4";
        ev(1, 0, 1, 1, 0, 0, 0);
        rd_expect(5'h00, 32'h2, "R4 first read");
        rd_expect(5'h00, 32'h0, "R4 cleared");
        ins_valid = 1; ins_bus = 0; ins_slot = 2; ins_hot = 1;
        rd_expect(5'h00, 32'h0, "R4 read with same-cycle insert");
        rd_expect(5'h00, 32'h4, "R4 insert survives clear");

        cur_req = "R9";
        ev(1, 0, 9, 1, 1, 0, 9);
        rd_expect(5'h04, 32'h0000_0200, "R9 remove bit");
        rd_expect(5'h00, 32'h0000_0200, "R9 insert bit");

        cur_req = "R6";
        wr(5'h08, 32'h0);
        wr(5'h08, 32'h0000_0E00);
        rd_expect(5'h04, 32'h0, "R6 remove retired");
        rd_expect(5'h00, 32'h0, "R6 insert retired");

        cur_req = "R7";
        wr(5'h10, 32'h1);
        ev(0, 0, 0, 0, 1, 1, 3);
        wr(5'h08, 32'h0000_0008);
        rd_expect(5'h04, 32'h0, "R7 fixed slot bits cleared");
        ev(0, 0, 0, 0, 1, 1, 4);
        wr(5'h08, 32'h0000_0030);

        cur_req = "R2";
        wr(5'h10, 32'h2);
        rd_expect(5'h10, 32'h2, "R2 select readback");

        cur_req = "R10";
        ev(1, 5, 0, 1, 1, 7, 1);
        rd_expect(5'h04, 32'h0, "R10 dropped event");

        cur_req = "R3";
        wr(5'h10, 32'h0);
        ev(0, 0, 0, 0, 1, 0, 4);
        wr(5'h10, 32'hDEAD_0007);
        rd_expect(5'h10, 32'h0, "R3 select reads zero");
        rd_expect(5'h0C, 32'h0, "R3 removable reads zero");
        wr(5'h08, 32'h0000_0010);
        wr(5'h10, 32'h0);
        rd_expect(5'h04, 32'h0000_0010, "R3 eject ignored");

        cur_req = "R5";
        legacy_mode = 1;
        ev(1, 0, 7, 1, 0, 0, 0);
        rd_expect(5'h00, 32'h0000_0080, "R5 legacy read 1");
        rd_expect(5'h00, 32'h0000_0080, "R5 legacy read 2");
        wr(5'h10, 32'h3);
        rd_expect(5'h10, 32'h0, "R5 select outside window");
        legacy_mode = 0;
        rd_expect(5'h10, 32'h0, "R5 select write ignored");
        rd_expect(5'h00, 32'h0000_0080, "R5 clearing read");

        cur_req = "R1";
        req_be = 4'h3;
        req_valid = 1; req_addr = 5'h04; @(negedge clk); idle();
        check("R1 partial access", rsp_rdata, 32'h0);
        rd_expect(5'h05, 32'h0, "R1 misaligned");
        rd_expect(5'h14, 32'h0, "R1 undecoded offset");
        rd_expect(5'h08, 32'h0, "R1 feature reads zero");

        cur_req = "R12";
        ev(0, 0, 0, 0, 1, 0, 2);
        ev(0, 0, 0, 0, 1, 0, 0);
        ev(0, 0, 0, 0, 1, 2, 31);
        ev(0, 0, 0, 0, 1, 1, 3);
        warm_rst = 1; @(negedge clk); idle();
        wr(5'h08, 32'h0000_0004);
        for (int i = 0; i < 50 && drain_busy; i++) @(negedge clk);
        check("R12 drain finished", 32'(drain_busy), 32'h0);
        for (int b = 0; b < NB; b++) begin
            wr(5'h10, 32'(b));
            rd_expect(5'h04, 32'h0, "R12 remove empty after drain");
        end
        wr(5'h10, 32'h1);
        rd_expect(5'h0C, 32'hFFFF_FFF7, "R12 removable reloaded");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule